// File: doc/BRIEF.md
# Alarm Annunciation Controller

This block turns a handful of condition flags into one annunciation state, and from that state into drive levels for four indicator lamps and a buzzer enable. The flags are: an alarm event, a loss-of-sensing flag, a general fault flag (an output that disagrees with its command, or a tripped protection), an intermittent trouble flag and a test request. The block also takes single-cycle silence and reset requests from an operator path.

Every state has exactly one lamp and buzzer code. Blinking and buzzer cadence come from a shared phase counter. A prescaled tick advances that counter once every `TICK_DIV` clocks. A trouble condition that lasts long enough is promoted to a fault. A test request plays a fixed pattern for a bounded number of ticks and then falls back to whatever the flags call for.

Every state change, every silence and every reset produces a one-clock event pulse with a code, so a logger downstream can record them. The code of the most recent event stays visible on its own port.

Top module: `annun_ctrl`

## Requirements
- R1: After rst_n is released, the state is Normal (state_o = 0), only led_pwr is lit, buzzer is 0, evt_valid is 0 and last_code is 0.
- R2: The state that the flags call for is chosen in this order. Sensing loss gives Fault (2). Alarm gives Alarm (1). The fault flag gives Fault. Escalated trouble gives Fault. Trouble gives Trouble (3). Otherwise the state is Normal (0). An alarm together with the plain fault flag stays Alarm. The state follows the flags one clock after they are sampled.
- R3: The phase p is floor(n / TICK_DIV) mod 16, where n is the number of clocks since reset. led_pwr is 1 in every state. Normal lights nothing else and keeps the buzzer off. Alarm drives led_alm = p[1] and buzzer = !p[2]. Fault drives led_flt = 1 and buzzer = p[0] & !p[3]. Trouble drives led_com = p[2] and buzzer = (p[2:0] == 0). Test drives led_alm = p[0], led_flt = !p[0], led_com = p[1] and buzzer = (p[1:0] == 3). Any lamp not listed for a state is 0.
- R4: A silence request forces the buzzer to 0. It leaves the state and all lamps unchanged, and it produces event code 8.
- R5: Silence holds until the next state change, after which the buzzer follows R3 again.
- R6: When trouble stays asserted for TRB_TICKS ticks, the state moves from Trouble to Fault. This happens between (TRB_TICKS-1)*TICK_DIV+1 and TRB_TICKS*TICK_DIV clocks after Trouble was entered.
- R7: A test request is taken only when neither alarm nor sensing loss is present. It enters Test (4). Test ends after TEST_TICKS ticks, between (TEST_TICKS-1)*TICK_DIV+1 and TEST_TICKS*TICK_DIV clocks after entry, and the block then goes to the state the flags call for. An alarm or sensing loss ends Test at once.
- R8: A reset request produces event code 9 and forces Normal on the next clock. It also clears silence, the trouble timer and Test. On the following clock the flags are evaluated again.
- R9: Every state change produces a single-clock evt_valid pulse with code state+1. last_code holds the most recent event code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_in | input | 1 | Alarm event present |
| fault_in | input | 1 | Output proof mismatch or protection trip |
| sense_lost_in | input | 1 | Input sensing no longer trustworthy |
| trouble_in | input | 1 | Intermittent trouble present |
| test_req | input | 1 | Start lamp/buzzer test (pulse) |
| silence_req | input | 1 | Mute buzzer (pulse) |
| reset_req | input | 1 | Re-initialize the state machine (pulse) |
| state_o | output | 3 | Current state: 0 Normal, 1 Alarm, 2 Fault, 3 Trouble, 4 Test |
| led_pwr | output | 1 | Power lamp |
| led_alm | output | 1 | Alarm lamp |
| led_flt | output | 1 | Fault lamp |
| led_com | output | 1 | Communication/trouble lamp |
| buzzer | output | 1 | Buzzer enable |
| evt_valid | output | 1 | One-clock event strobe |
| evt_code | output | 4 | Event code, valid with evt_valid |
| last_code | output | 4 | Most recent event code |

## Verification
The properties assume that reset_req, silence_req and test_req are single-cycle strobes. They also assume that the condition flags change only between clock edges and are never X after reset. The stimulus drives every input on the falling edge and raises each request for exactly one clock. It holds the flags steady while a lamp pattern is sampled, so that a blink window never spans a state change. Requests that coincide with a state change are not driven, because the order of the event log is then defined only by the priority among reset, state change and silence.

// File: rtl/annun_pkg.sv
package annun_pkg;

  localparam int unsigned PH_W = 4;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_ALARM   = 3'd1,
    ST_FAULT   = 3'd2,
    ST_TROUBLE = 3'd3,
    ST_TEST    = 3'd4
  } ann_state_e;

  typedef struct packed {
    logic pwr;
    logic alm;
    logic flt;
    logic com;
    logic buz;
  } ann_ind_t;

  localparam logic [3:0] EV_SILENCE = 4'd8;
  localparam logic [3:0] EV_RESET   = 4'd9;

  // State-entry event code: state encoding plus one.
  function automatic logic [3:0] state_code(input ann_state_e s);
    return {1'b0, s} + 4'd1;
  endfunction

  // Flag priority: sensing loss, alarm, fault, escalated trouble, trouble.
  function automatic ann_state_e resolve(input logic alarm, input logic fault,
                                         input logic lost, input logic trouble,
                                         input logic escalated);
    if (lost)                     return ST_FAULT;
    else if (alarm)               return ST_ALARM;
    else if (fault)               return ST_FAULT;
    else if (trouble && escalated) return ST_FAULT;
    else if (trouble)             return ST_TROUBLE;
    else                          return ST_NORMAL;
  endfunction

  // One fixed lamp/buzzer code per state, driven by the tick phase.
  function automatic ann_ind_t ind_pattern(input ann_state_e s,
                                           input logic [PH_W-1:0] ph,
                                           input logic mute);
    ann_ind_t r;
    r = '0;
    r.pwr = 1'b1;
    case (s)
      ST_ALARM: begin
        r.alm = ph[1];
        r.buz = ~ph[2];
      end
      ST_FAULT: begin
        r.flt = 1'b1;
        r.buz = ph[0] & ~ph[3];
      end
      ST_TROUBLE: begin
        r.com = ph[2];
        r.buz = (ph[2:0] == 3'd0);
      end
      ST_TEST: begin
        r.alm = ph[0];
        r.flt = ~ph[0];
        r.com = ph[1];
        r.buz = (ph[1:0] == 2'd3);
      end
      default: ;
    endcase
    if (mute) r.buz = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/annun_tick.sv
module annun_tick #(
  parameter int unsigned DIV  = 1000,
  parameter int unsigned PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            tick,
  output logic [PH_W-1:0] phase
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= '0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= phase + 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/annun_fsm.sv
module annun_fsm
  import annun_pkg::*;
#(
  parameter int unsigned TRB_TICKS  = 30,
  parameter int unsigned TEST_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       alarm_in,
  input  logic       fault_in,
  input  logic       sense_lost_in,
  input  logic       trouble_in,
  input  logic       test_req,
  input  logic       silence_req,
  input  logic       reset_req,
  output ann_state_e state_q,
  output logic       mute_q,
  output logic       evt_valid,
  output logic [3:0] evt_code,
  output logic [3:0] last_code,
  output logic       state_chg,
  output logic       trb_escalated
);

  localparam int unsigned TW = $clog2(TRB_TICKS + 1);
  localparam int unsigned XW = $clog2(TEST_TICKS + 1);
  localparam logic [TW-1:0] TRB_LIM  = TW'(TRB_TICKS);
  localparam logic [XW-1:0] TEST_END = XW'(TEST_TICKS - 1);

  logic [TW-1:0] trb_cnt;
  logic [XW-1:0] test_cnt;
  logic          sil_pend;
  ann_state_e    natural_st;
  ann_state_e    nxt_state;
  logic          urgent;
  logic          test_done;
  logic          sil_emit;
  logic          ev_v_n;
  logic [3:0]    ev_c_n;

  assign trb_escalated = (trb_cnt == TRB_LIM);
  assign urgent        = alarm_in | sense_lost_in;
  assign test_done     = tick && (test_cnt == TEST_END);

  always_comb begin
    natural_st = resolve(alarm_in, fault_in, sense_lost_in, trouble_in, trb_escalated);
    if (reset_req)
      nxt_state = ST_NORMAL;
    else if (state_q == ST_TEST)
      nxt_state = (urgent || test_done) ? natural_st : ST_TEST;
    else if (test_req && !urgent)
      nxt_state = ST_TEST;
    else
      nxt_state = natural_st;
  end

  assign state_chg = !reset_req && (nxt_state != state_q);
  assign sil_emit  = !reset_req && !state_chg && (sil_pend || silence_req);

  always_comb begin
    ev_v_n = 1'b1;
    if (reset_req)      ev_c_n = EV_RESET;
    else if (state_chg) ev_c_n = state_code(nxt_state);
    else if (sil_emit)  ev_c_n = EV_SILENCE;
    else begin
      ev_v_n = 1'b0;
      ev_c_n = 4'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_NORMAL;
      mute_q    <= 1'b0;
      sil_pend  <= 1'b0;
      trb_cnt   <= '0;
      test_cnt  <= '0;
      evt_valid <= 1'b0;
      evt_code  <= '0;
      last_code <= '0;
    end else begin
      state_q   <= nxt_state;
      mute_q    <= silence_req | (mute_q & ~state_chg & ~reset_req);
      sil_pend  <= (sil_pend | silence_req) & ~sil_emit;
      evt_valid <= ev_v_n;
      evt_code  <= ev_c_n;
      if (ev_v_n) last_code <= ev_c_n;

      if (reset_req || !trouble_in)         trb_cnt <= '0;
      else if (tick && !trb_escalated)      trb_cnt <= trb_cnt + 1'b1;

      if (nxt_state == ST_TEST && state_q != ST_TEST) test_cnt <= '0;
      else if (state_q == ST_TEST && tick)           test_cnt <= test_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/annun_enc.sv
module annun_enc
  import annun_pkg::*;
(
  input  ann_state_e      state_q,
  input  logic [PH_W-1:0] phase,
  input  logic            mute_q,
  output logic            led_pwr,
  output logic            led_alm,
  output logic            led_flt,
  output logic            led_com,
  output logic            buzzer
);

  ann_ind_t ind;

  always_comb ind = ind_pattern(state_q, phase, mute_q);

  assign led_pwr = ind.pwr;
  assign led_alm = ind.alm;
  assign led_flt = ind.flt;
  assign led_com = ind.com;
  assign buzzer  = ind.buz;

endmodule

// File: rtl/annun_ctrl.sv
module annun_ctrl
  import annun_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 1000,
  parameter int unsigned TRB_TICKS  = 30,
  parameter int unsigned TEST_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alarm_in,
  input  logic       fault_in,
  input  logic       sense_lost_in,
  input  logic       trouble_in,
  input  logic       test_req,
  input  logic       silence_req,
  input  logic       reset_req,
  output logic [2:0] state_o,
  output logic       led_pwr,
  output logic       led_alm,
  output logic       led_flt,
  output logic       led_com,
  output logic       buzzer,
  output logic       evt_valid,
  output logic [3:0] evt_code,
  output logic [3:0] last_code
);

  logic            tick;
  logic [PH_W-1:0] phase;
  ann_state_e      state_q;
  logic            silence_active;
  logic            state_chg;
  logic            trb_escalated;

  annun_tick #(.DIV(TICK_DIV), .PH_W(PH_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .phase (phase)
  );

  annun_fsm #(.TRB_TICKS(TRB_TICKS), .TEST_TICKS(TEST_TICKS)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .alarm_in      (alarm_in),
    .fault_in      (fault_in),
    .sense_lost_in (sense_lost_in),
    .trouble_in    (trouble_in),
    .test_req      (test_req),
    .silence_req   (silence_req),
    .reset_req     (reset_req),
    .state_q       (state_q),
    .mute_q        (silence_active),
    .evt_valid     (evt_valid),
    .evt_code      (evt_code),
    .last_code     (last_code),
    .state_chg     (state_chg),
    .trb_escalated (trb_escalated)
  );

  annun_enc u_enc (
    .state_q (state_q),
    .phase   (phase),
    .mute_q  (silence_active),
    .led_pwr (led_pwr),
    .led_alm (led_alm),
    .led_flt (led_flt),
    .led_com (led_com),
    .buzzer  (buzzer)
  );

  assign state_o = state_q;

endmodule

// File: rtl/annun_ctrl_chk.sv
module annun_ctrl_chk #(
  parameter int unsigned TICK_DIV   = 1000,
  parameter int unsigned TEST_TICKS = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sense_lost_in,
  input logic       reset_req,
  input logic [2:0] state_o,
  input logic       led_pwr,
  input logic       led_alm,
  input logic       led_flt,
  input logic       led_com,
  input logic       buzzer,
  input logic       evt_valid,
  input logic [3:0] evt_code,
  input logic       silence_active
);

  localparam int unsigned TEST_MAX = TEST_TICKS * TICK_DIV;
  localparam int unsigned RW = $clog2(TEST_MAX + 2);

  logic [RW-1:0] test_run;

  always_ff @(posedge clk) begin
    if (!rst_n || state_o != 3'd4) test_run <= '0;
    else if (test_run != '1)       test_run <= test_run + 1'b1;
  end

  // R9: a change of state is always announced
  a_r9_change_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != $past(state_o)) |-> evt_valid);

  // R4: muted buzzer stays quiet
  a_r4_mute_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    silence_active |-> !buzzer);

  // R8: reset request lands in Normal with its event
  a_r8_reset_normal: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (state_o == 3'd0 && evt_valid && evt_code == 4'd9));

  // R2: sensing loss forces Fault
  a_r2_lost_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_lost_in && !reset_req) |=> (state_o == 3'd2));

  // R3: Normal shows power only
  a_r3_normal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> (led_pwr && !led_alm && !led_flt && !led_com && !buzzer));

  // R7: test never outlasts its window
  a_r7_test_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(test_run) <= int'(TEST_MAX)));

endmodule

bind annun_ctrl annun_ctrl_chk #(.TICK_DIV(TICK_DIV), .TEST_TICKS(TEST_TICKS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sense_lost_in  (sense_lost_in),
  .reset_req      (reset_req),
  .state_o        (state_o),
  .led_pwr        (led_pwr),
  .led_alm        (led_alm),
  .led_flt        (led_flt),
  .led_com        (led_com),
  .buzzer         (buzzer),
  .evt_valid      (evt_valid),
  .evt_code       (evt_code),
  .silence_active (silence_active)
);

// File: tb/annun_ctrl_tb.sv
module annun_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int TRB  = 5;
  localparam int TST  = 6;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alarm_in = 0, fault_in = 0, sense_lost_in = 0, trouble_in = 0;
  logic test_req = 0, silence_req = 0, reset_req = 0;
  logic [2:0] state_o;
  logic led_pwr, led_alm, led_flt, led_com, buzzer, evt_valid;
  logic [3:0] evt_code, last_code;

  int n_cmp = 0;
  int n_bad = 0;
  int n = 0;
  int ev_time [16];
  logic [3:0] exp_q [$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  annun_ctrl #(.TICK_DIV(DIV), .TRB_TICKS(TRB), .TEST_TICKS(TST)) u_dut (
    .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .fault_in(fault_in),
    .sense_lost_in(sense_lost_in), .trouble_in(trouble_in), .test_req(test_req),
    .silence_req(silence_req), .reset_req(reset_req), .state_o(state_o),
    .led_pwr(led_pwr), .led_alm(led_alm), .led_flt(led_flt), .led_com(led_com),
    .buzzer(buzzer), .evt_valid(evt_valid), .evt_code(evt_code), .last_code(last_code)
  );

  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else n <= n + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // Expected lamps as {pwr,alm,flt,com,buz}, written from the R3 table.
  function automatic logic [4:0] want(input int st, input int ph, input bit mute);
    logic [4:0] w;
    bit b0, b1, b2, b3;
    b0 = ph % 2 == 1; b1 = (ph / 2) % 2 == 1; b2 = (ph / 4) % 2 == 1; b3 = ph >= 8;
    case (st)
      1:       w = {1'b1, b1, 1'b0, 1'b0, !b2};
      2:       w = {1'b1, 1'b0, 1'b1, 1'b0, b0 && !b3};
      3:       w = {1'b1, 1'b0, 1'b0, b2, (ph % 8) == 0};
      4:       w = {1'b1, b0, !b0, b1, (ph % 4) == 3};
      default: w = 5'b10000;
    endcase
    if (mute) w[0] = 1'b0;
    return w;
  endfunction

  task automatic chk_lamps(input string req, input int st, input bit mute, input int cycles);
    int bad = 0;
    logic [4:0] got, w;
    logic [4:0] got_bad = '0, w_bad = '0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      got = {led_pwr, led_alm, led_flt, led_com, buzzer};
      w = want(st, (n / DIV) % 16, mute);
      if (got != w || state_o != 3'(st)) begin
        if (bad == 0) begin got_bad = got; w_bad = w; end
        bad++;
      end
    end
    n_cmp++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL %s: actual lamps %b expected %b", req, got_bad, w_bad);
    end
  endtask

  task automatic expect_ev(input logic [3:0] c);
    exp_q.push_back(c);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every event strobe
  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      ev_time[evt_code] = n;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9: actual event %0d expected none", evt_code);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        if (e != evt_code) begin
          n_bad++;
          $display("FAIL R9: actual event %0d expected %0d", evt_code, e);
        end
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 evt", evt_valid, 0);
    chk("R1 last", last_code, 0);
    chk_lamps("R1 lamps", 0, 0, 8);

    // R2/R3 alarm
    expect_ev(4'd2);
    @(negedge clk); alarm_in = 1;
    idle(2);
    chk_lamps("R3 alarm", 1, 0, 40);
    // R4 silence: buzzer only
    expect_ev(4'd8);
    pulse(silence_req);
    idle(1);
    chk_lamps("R4 alarm muted", 1, 1, 40);
    chk("R9 last_code", last_code, 8);
    // R2 sensing loss over alarm; R5 silence lifted
    expect_ev(4'd3);
    @(negedge clk); sense_lost_in = 1;
    idle(2);
    chk_lamps("R5 fault unmuted", 2, 0, 64);
    expect_ev(4'd2);
    @(negedge clk); sense_lost_in = 0;
    idle(2);
    // R2 plain fault does not override alarm
    @(negedge clk); fault_in = 1;
    idle(3);
    chk("R2 alarm over fault", state_o, 1);
    expect_ev(4'd3);
    @(negedge clk); alarm_in = 0;
    idle(2);
    chk("R2 fault alone", state_o, 2);
    expect_ev(4'd1);
    @(negedge clk); fault_in = 0;
    idle(2);
    chk("R2 back normal", state_o, 0);

    // R6 trouble escalation
    expect_ev(4'd4);
    expect_ev(4'd3);
    @(negedge clk); trouble_in = 1;
    idle(1);
    chk_lamps("R3 trouble", 3, 0, 10);
    idle(20);
    chk("R6 escalated", state_o, 2);
    chk_range("R6 delay", ev_time[3] - ev_time[4], (TRB-1)*DIV+1, TRB*DIV);
    expect_ev(4'd1);
    @(negedge clk); trouble_in = 0;
    idle(2);

    // R7 test duration
    expect_ev(4'd5);
    expect_ev(4'd1);
    pulse(test_req);
    chk_lamps("R3 test", 4, 0, 16);
    idle(14);
    chk("R7 returned", state_o, 0);
    chk_range("R7 duration", ev_time[1] - ev_time[5], (TST-1)*DIV+1, TST*DIV);
    // R7 alarm aborts test
    expect_ev(4'd5);
    expect_ev(4'd2);
    pulse(test_req);
    @(negedge clk); alarm_in = 1;
    idle(2);
    chk("R7 abort", state_o, 1);
    // R7 test refused during alarm
    pulse(test_req);
    idle(2);
    chk("R7 refused", state_o, 1);
    expect_ev(4'd1);
    @(negedge clk); alarm_in = 0;
    idle(2);

    // R8 reset re-evaluates flags
    expect_ev(4'd3);
    @(negedge clk); fault_in = 1;
    idle(2);
    expect_ev(4'd8);
    pulse(silence_req);
    idle(2);
    expect_ev(4'd9);
    expect_ev(4'd3);
    @(negedge clk); reset_req = 1;
    @(negedge clk); reset_req = 0;
    chk("R8 normal after reset", state_o, 0);
    @(negedge clk);
    chk("R8 re-evaluated", state_o, 2);
    chk("R9 last after reset", last_code, 3);
    chk_lamps("R8 mute cleared", 2, 0, 32);
    expect_ev(4'd1);
    @(negedge clk); fault_in = 0;
    idle(4);

    chk("R9 queue empty", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule